// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Port

This block is a clocked serial transceiver built from three wires: a transmit line, a receive line and one serial clock that both directions share. A host writes a character into a transmit holding register. The character then moves into a transmit shift register and leaves the block least significant bit first, wrapped in a low start bit and one or two high stop bits. Each direction has two stages of buffering, so the host can queue the next character while the current one is still shifting out. It can also leave a received character unread while the next one arrives.

Transmit data changes after a rising serial clock edge, and receive data is sampled on a falling edge. The serial clock is either generated inside the block by a programmable divider and driven out, or taken from an external pin. An external clock and the receive line pass through a synchronizer before use. All logic runs on the system clock, and serial edges are detected as single-cycle events.

Top module: `sync_serial_port`

## Requirements
- R1: After reset `txd` is 1, `tx_empty` is 1, `tx_busy` is 0, `rx_full` is 0, `rx_overrun` is 0 and `sclk_out` is 0.
- R2: When `cfg_ext_clk` is 0, `sclk_oe` is 1 and `sclk_out` toggles every `cfg_div`+1 system clock cycles. When `cfg_ext_clk` is 1, `sclk_oe` is 0 and `sclk_out` is held at 0.
- R3: A character is sent in this order: a start bit of 0, then DATA_W data bits starting with bit 0, then one stop bit of 1 (two when `cfg_two_stop` is 1). `txd` changes only in the cycle after a rising serial clock edge has been detected.
- R4: A write (`tx_wr` high while `tx_empty` is 1) clears `tx_empty` on the next cycle. `tx_empty` sets again when the held character moves into the shift register. A write while `tx_empty` is 0 is ignored.
- R5: `tx_busy` goes high on an accepted write. It falls only after the last stop bit of the final character has gone out and the holding register is empty.
- R6: A character waiting in the holding register starts with its start bit right after the previous character's last stop bit, with no idle bit between them.
- R7: The receiver waits for a 0 sampled on a falling edge (the start bit). It shifts in DATA_W data bits LSB first on the following falling edges. After the last stop-bit edge it copies the character to `rx_data` and sets `rx_full`.
- R8: A pulse on `rx_rd` clears `rx_full` on the next cycle, unless a new character completes in that same cycle.
- R9: If a character completes while `rx_full` is 1 and no read happens in that cycle, `rx_overrun` sets and `rx_data` takes the new character. `rx_rd` clears `rx_overrun`.
- R10: With `cfg_ext_clk` at 1, the edges of `sclk_in` clock both transmit and receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ext_clk | input | 1 | 1 selects the external serial clock, 0 selects the internal divider |
| cfg_two_stop | input | 1 | 1 selects two stop bits per character |
| cfg_div | input | DIV_W | Divider terminal count; half period of the internal clock is cfg_div+1 cycles |
| sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Internally generated serial clock |
| sclk_oe | output | 1 | Output enable for the serial clock pin |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |
| tx_wr | input | 1 | Host write strobe for the transmit holding register |
| tx_data | input | DATA_W | Character to transmit |
| tx_empty | output | 1 | Transmit holding register is empty |
| tx_busy | output | 1 | A character is being sent or is waiting to be sent |
| rx_rd | input | 1 | Host read strobe for the receive holding register |
| rx_data | output | DATA_W | Last received character |
| rx_full | output | 1 | Receive holding register holds an unread character |
| rx_overrun | output | 1 | A character was replaced before it was read |

## Verification
Several properties are checked on every cycle. `txd` moves only after a detected rising edge. A write to an empty holding register clears `tx_empty`. `tx_busy` falls only at the end of a stop bit. The internal clock toggles only at terminal count and stays low under external clocking. A completion sets `rx_full`, a read clears it, and a completion into a full buffer sets the overrun bit. Other behaviour can only be shown by the bench's scenarios. These include the exact bit order on the line, one versus two stop bits, and gap-free back-to-back transmission. They also include dropping a write to a full holding register, the divider's period, and character replacement on overrun under an external clock.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
   typedef enum logic {
      SRC_DIVIDER = 1'b0,
      SRC_PIN     = 1'b1
   } sclk_src_e;

   localparam int unsigned SSP_MIN_DATA_W = 5;
   localparam int unsigned SSP_MAX_DATA_W = 9;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ssp_clkgen.sv
module ssp_clkgen
   import ssp_pkg::*;
#(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  sclk_src_e        src,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic             pin_sclk_s,
   output logic             sclk_gen,
   output logic             rise_ev,
   output logic             fall_ev
);
   logic [DIV_W-1:0] cnt_q;
   logic             gen_q;
   logic             prev_q;
   logic             sel;

   // divider: held cleared while the pin is the clock source
   always_ff @(posedge clk) begin
      if (!rst_n || src == SRC_PIN) begin
         cnt_q <= '0;
         gen_q <= 1'b0;
      end else if (cnt_q >= cfg_div) begin
         cnt_q <= '0;
         gen_q <= ~gen_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign sel = (src == SRC_PIN) ? pin_sclk_s : gen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sel;
   end

   assign rise_ev  = sel & ~prev_q;
   assign fall_ev  = ~sel & prev_q;
   assign sclk_gen = gen_q;

   // R2: internal clock only flips at terminal count
   p_toggle_at_tc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_DIVIDER && $past(src == SRC_DIVIDER) && !$stable(gen_q))
         |-> $past(cnt_q >= cfg_div));
   // R2: external selection parks the generated clock low
   p_park_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_PIN) |=> !gen_q);
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise_ev,
   input  logic              cfg_two_stop,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              txd,
   output logic              tx_empty,
   output logic              tx_busy
);
   localparam int unsigned CNT_W = $clog2(DATA_W + 3);

   logic [DATA_W-1:0] hold_q;
   logic              hold_full_q;
   logic [DATA_W+1:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              busy_q;
   logic              txd_q;
   logic [CNT_W-1:0]  last_idx;
   logic              wr_ok;
   logic              at_last;
   logic              load;

   assign last_idx = CNT_W'(DATA_W) + (cfg_two_stop ? CNT_W'(2) : CNT_W'(1));
   assign wr_ok    = wr_en & ~hold_full_q;
   assign at_last  = busy_q & (cnt_q == last_idx);
   assign load     = rise_ev & hold_full_q & (~busy_q | at_last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q      <= '0;
         hold_full_q <= 1'b0;
      end else begin
         hold_full_q <= (hold_full_q & ~load) | wr_ok;
         if (wr_ok) hold_q <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '1;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         txd_q  <= 1'b1;
      end else if (load) begin
         sh_q   <= {2'b11, hold_q};
         cnt_q  <= '0;
         busy_q <= 1'b1;
         txd_q  <= 1'b0;
      end else if (rise_ev && busy_q) begin
         if (at_last) begin
            busy_q <= 1'b0;
            txd_q  <= 1'b1;
         end else begin
            txd_q <= sh_q[0];
            sh_q  <= {1'b1, sh_q[DATA_W+1:1]};
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign txd      = txd_q;
   assign tx_empty = ~hold_full_q;
   assign tx_busy  = busy_q | hold_full_q;

   // R3: line moves only after a detected rising serial edge
   p_txd_after_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(txd_q) |-> $past(rise_ev));
   // R4: accepted write empties nothing, it fills the holding stage
   p_write_fills_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && tx_empty) |=> !tx_empty);
   // R5: busy ends only at a rising edge, with the line idle high
   p_busy_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_busy) |-> ($past(rise_ev) && txd_q));
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fall_ev,
   input  logic              cfg_two_stop,
   input  logic              rxd_s,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              rx_overrun
);
   localparam int unsigned CNT_W = $clog2(DATA_W + 2);

   logic              active_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] buf_q;
   logic              full_q;
   logic              ovr_q;
   logic [CNT_W-1:0]  last_idx;
   logic              done;

   assign last_idx = CNT_W'(DATA_W) + (cfg_two_stop ? CNT_W'(1) : CNT_W'(0));
   assign done     = fall_ev & active_q & (cnt_q == last_idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         sh_q     <= '0;
      end else if (fall_ev) begin
         if (!active_q) begin
            if (!rxd_s) begin
               active_q <= 1'b1;
               cnt_q    <= '0;
            end
         end else begin
            if (cnt_q < CNT_W'(DATA_W)) sh_q <= {rxd_s, sh_q[DATA_W-1:1]};
            if (done) active_q <= 1'b0;
            else      cnt_q    <= cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_q  <= '0;
         full_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         if (done) buf_q <= sh_q;
         if (done)       full_q <= 1'b1;
         else if (rd_en) full_q <= 1'b0;
         if (done && full_q && !rd_en) ovr_q <= 1'b1;
         else if (rd_en)               ovr_q <= 1'b0;
      end
   end

   assign rx_data    = buf_q;
   assign rx_full    = full_q;
   assign rx_overrun = ovr_q;

   // R7: a completed character always lands as full
   p_done_sets_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> full_q);
   // R8: a read with no completion empties the buffer
   p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !done) |=> !full_q);
   // R9: completion into an unread buffer flags overrun
   p_overrun_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && full_q && !rd_en) |=> ovr_q);
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
   import ssp_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DIV_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_ext_clk,
   input  logic              cfg_two_stop,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              sclk_in,
   output logic              sclk_out,
   output logic              sclk_oe,
   output logic              txd,
   input  logic              rxd,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_empty,
   output logic              tx_busy,
   input  logic              rx_rd,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              rx_overrun
);
   if (DATA_W < SSP_MIN_DATA_W || DATA_W > SSP_MAX_DATA_W) begin : g_bad_data_w
      $error("DATA_W out of supported range");
   end
   if (DIV_W < 2) begin : g_bad_div_w
      $error("DIV_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   sclk_src_e src;
   logic [1:0] pins_s;
   logic       rise_ev;
   logic       fall_ev;

   assign src = cfg_ext_clk ? SRC_PIN : SRC_DIVIDER;

   ssp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sclk_in, rxd}),
      .q     (pins_s)
   );

   ssp_clkgen #(.DIV_W(DIV_W)) u_clkgen (
      .clk        (clk),
      .rst_n      (rst_n),
      .src        (src),
      .cfg_div    (cfg_div),
      .pin_sclk_s (pins_s[1]),
      .sclk_gen   (sclk_out),
      .rise_ev    (rise_ev),
      .fall_ev    (fall_ev)
   );

   assign sclk_oe = (src == SRC_DIVIDER);

   ssp_tx #(.DATA_W(DATA_W)) u_tx (
      .clk          (clk),
      .rst_n        (rst_n),
      .rise_ev      (rise_ev),
      .cfg_two_stop (cfg_two_stop),
      .wr_en        (tx_wr),
      .wr_data      (tx_data),
      .txd          (txd),
      .tx_empty     (tx_empty),
      .tx_busy      (tx_busy)
   );

   ssp_rx #(.DATA_W(DATA_W)) u_rx (
      .clk          (clk),
      .rst_n        (rst_n),
      .fall_ev      (fall_ev),
      .cfg_two_stop (cfg_two_stop),
      .rxd_s        (pins_s[0]),
      .rd_en        (rx_rd),
      .rx_data      (rx_data),
      .rx_full      (rx_full),
      .rx_overrun   (rx_overrun)
   );

   // R2: the pin driver follows the source selection
   p_oe_matches_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_oe != cfg_ext_clk);
endmodule

// File: tb/sync_serial_port_tb.sv
`timescale 1ns/1ps
module sync_serial_port_tb;
   localparam int DW = 8;
   localparam int VW = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cfg_ext_clk, cfg_two_stop;
   logic [VW-1:0] cfg_div;
   logic          sclk_in, sclk_out, sclk_oe, txd, rxd, rxd_drv, loop_en;
   logic          tx_wr, tx_empty, tx_busy, rx_rd, rx_full, rx_overrun;
   logic [DW-1:0] tx_data, rx_data;

   int nchk = 0;
   int nerr = 0;
   logic [DW-1:0] exp_q[$];
   bit   auto_rd = 1'b1;
   bit   logging = 1'b0;
   bit   elogging = 1'b0;
   logic lg [0:63];
   int   nlog = 0;

   always #2 clk = ~clk;

   assign rxd = loop_en ? txd : rxd_drv;

   sync_serial_port #(.DATA_W(DW), .DIV_W(VW), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_ext_clk(cfg_ext_clk), .cfg_two_stop(cfg_two_stop),
      .cfg_div(cfg_div), .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
      .txd(txd), .rxd(rxd), .tx_wr(tx_wr), .tx_data(tx_data), .tx_empty(tx_empty),
      .tx_busy(tx_busy), .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full),
      .rx_overrun(rx_overrun)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   endtask

   // line loggers: txd seen at each falling serial edge
   always @(negedge sclk_out) if (logging && nlog < 64) begin lg[nlog] = txd; nlog++; end
   always @(negedge sclk_in)  if (elogging && nlog < 64) begin lg[nlog] = txd; nlog++; end

   function automatic logic [DW-1:0] log_byte(input int s);
      logic [DW-1:0] v;
      for (int i = 0; i < DW; i++) v[i] = lg[s + i];
      return v;
   endfunction

   function automatic int first_low();
      for (int i = 0; i < nlog; i++) if (lg[i] == 1'b0) return i;
      return 0;
   endfunction

   // driver: write a character, optionally expecting it back through loopback
   task automatic send(input logic [DW-1:0] d, input bit expect_back);
      @(negedge clk);
      tx_wr = 1'b1; tx_data = d;
      @(negedge clk);
      tx_wr = 1'b0;
      if (expect_back) exp_q.push_back(d);
   endtask

   task automatic drain();
      for (int i = 0; i < 4000 && exp_q.size() != 0; i++) @(negedge clk);
      chk("R7 scoreboard drained", exp_q.size(), 0);
   endtask

   // external clock frame on rxd, one bit per sclk_in period
   task automatic ext_frame(input logic [DW-1:0] d);
      logic [DW+1:0] f;
      f = {1'b1, d, 1'b0};
      for (int i = 0; i < DW + 2; i++) begin
         @(negedge clk); sclk_in = 1'b1; rxd_drv = f[i];
         repeat (8) @(negedge clk);
         sclk_in = 1'b0;
         repeat (8) @(negedge clk);
      end
   endtask

   // monitor: pops the scoreboard as characters arrive
   initial begin
      rx_rd = 1'b0;
      forever begin
         @(negedge clk);
         if (auto_rd && rx_full) begin
            if (exp_q.size() == 0) chk("R7 unexpected character", rx_data, 32'hFFFF);
            else chk("R7 received character", rx_data, exp_q.pop_front());
            rx_rd = 1'b1;
            @(negedge clk);
            rx_rd = 1'b0;
            @(negedge clk);
            chk("R8 full cleared by read", rx_full, 0);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int n, s;
      rst_n = 1'b0; cfg_ext_clk = 1'b0; cfg_two_stop = 1'b0; cfg_div = 16'd3;
      sclk_in = 1'b0; rxd_drv = 1'b1; loop_en = 1'b1; tx_wr = 1'b0; tx_data = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 txd idle", txd, 1);
      chk("R1 tx_empty", tx_empty, 1);
      chk("R1 tx_busy", tx_busy, 0);
      chk("R1 rx_full", rx_full, 0);
      chk("R1 rx_overrun", rx_overrun, 0);
      chk("R1 sclk_out", sclk_out, 0);
      chk("R2 sclk_oe internal", sclk_oe, 1);

      // R2: half period of the divider
      @(posedge sclk_out);
      n = 0;
      while (sclk_out) begin @(posedge clk); #1; n++; end
      chk("R2 high half period", n, 4);
      n = 0;
      while (!sclk_out) begin @(posedge clk); #1; n++; end
      chk("R2 low half period", n, 4);

      // R3/R4/R5/R6: back-to-back characters, one stop bit
      nlog = 0; logging = 1'b1;
      send(8'hA5, 1'b1);
      chk("R4 empty cleared by write", tx_empty, 0);
      chk("R5 busy after write", tx_busy, 1);
      wait (tx_busy && tx_empty);
      send(8'h3C, 1'b1);
      @(negedge clk);
      tx_wr = 1'b1; tx_data = 8'hFF;   // R4: holding stage full, must be dropped
      @(negedge clk);
      tx_wr = 1'b0;
      chk("R4 still full after dropped write", tx_empty, 0);
      wait (!tx_busy);
      @(negedge clk);
      logging = 1'b0;
      chk("R5 line idle when busy ends", txd, 1);
      s = first_low();
      chk("R5 last stop bit sent before busy fell", (nlog >= s + 20), 1);
      chk("R3 first character bits", log_byte(s + 1), 8'hA5);
      chk("R3 first stop bit", lg[s + 9], 1);
      chk("R6 next start follows at once", lg[s + 10], 0);
      chk("R3 second character bits", log_byte(s + 11), 8'h3C);
      chk("R3 second stop bit", lg[s + 19], 1);
      drain();

      // R3: two stop bits
      cfg_two_stop = 1'b1;
      nlog = 0; logging = 1'b1;
      send(8'h96, 1'b1);
      wait (!tx_busy);
      @(negedge clk);
      logging = 1'b0;
      s = first_low();
      chk("R3 two-stop character bits", log_byte(s + 1), 8'h96);
      chk("R3 two-stop first stop", lg[s + 9], 1);
      chk("R3 two-stop second stop", lg[s + 10], 1);
      chk("R5 both stops out before busy fell", (nlog >= s + 11), 1);
      drain();

      // R10/R9: external clock, receiver fed directly
      auto_rd = 1'b0; loop_en = 1'b0; cfg_two_stop = 1'b0; cfg_ext_clk = 1'b1;
      repeat (4) @(negedge clk);
      chk("R2 sclk_oe external", sclk_oe, 0);
      chk("R2 sclk_out parked", sclk_out, 0);
      send(8'h81, 1'b0);
      nlog = 0; elogging = 1'b1;
      ext_frame(8'h5A);
      elogging = 1'b0;
      chk("R10 received on external clock", rx_data, 8'h5A);
      chk("R10 full on external clock", rx_full, 1);
      chk("R9 no overrun yet", rx_overrun, 0);
      chk("R10 tx start on external clock", lg[0], 0);
      chk("R10 tx bits on external clock", log_byte(1), 8'h81);
      chk("R10 tx stop on external clock", lg[9], 1);
      ext_frame(8'hC3);
      chk("R9 overrun set", rx_overrun, 1);
      chk("R9 new character replaces old", rx_data, 8'hC3);
      chk("R9 buffer still full", rx_full, 1);
      exp_q.push_back(8'hC3);
      auto_rd = 1'b1;
      drain();
      repeat (3) @(negedge clk);
      chk("R9 overrun cleared by read", rx_overrun, 0);
      chk("R8 buffer empty after read", rx_full, 0);
      finish_run();
   end
endmodule